// File: doc/BRIEF.md
# Accumulator Step Unit

This block holds an 8-bit working byte and changes it one step at a time under control of an opcode byte. It has no adder and no logic datapath. Each operation moves the byte a short, fixed distance: it counts up or down by one in plain binary or in two-digit packed decimal, clears the byte, inverts it, shifts it one place, forces a single bit high or low, or takes a new byte from an outside register value.

A sequencer drives `opcode` and raises `exec` for one clock during the execute phase. On that rising edge the unit decodes the opcode and a per-bit multiplexer picks the next value of every bit at once. Opcodes that are not listed below, and every cycle with `exec` low, leave the byte and the wrap flag unchanged. The register file sits outside the block. For a load, the caller places the chosen register's contents on `reg_data`, and the low nibble of the opcode plays no part inside the block.

Counting uses a toggle chain inside each 4-bit digit. The carry from the low digit into the high digit is decoded directly from the low digit's value and does not ripple through its four bits.

Top module: `accum_step_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc` is 0x00, `acc_ovf` is 0 and `acc_zero` is 1.
- R2: Opcode 0x00 adds one modulo 256 and opcode 0x01 subtracts one modulo 256. `acc_ovf` becomes 1 when 0xFF steps to 0x00 or 0x00 steps to 0xFF, and becomes 0 on any other of these steps.
- R3: Opcode 0x02 counts up in packed decimal (two digits, one per nibble). A digit of 9 goes to 0 and carries into the next digit. 0x99 goes to 0x00 with `acc_ovf` set to 1; any other step clears `acc_ovf`.
- R4: Opcode 0x03 counts down in packed decimal. A digit of 0 goes to 9 and borrows from the next digit. 0x00 goes to 0x99 with `acc_ovf` set to 1; any other step clears `acc_ovf`.
- R5: Opcode 0x04 sets `acc` to 0x00.
- R6: Opcode 0x05 replaces `acc` with its bitwise inverse.
- R7: Opcode 0x06 shifts `acc` one place toward the MSB and opcode 0x07 shifts it one place toward the LSB. In both cases a 0 enters at the vacated end.
- R8: Opcode 0x80+b (b in 0..7) sets bit b of `acc`. Opcode 0x88+b clears bit b. No other bit changes.
- R9: An opcode of the form 0x6r (r = 0..15) loads `acc` from `reg_data`.
- R10: With `exec` low, or with an opcode outside those listed (for example 0x20), `acc` and `acc_ovf` keep their values.
- R11: `acc_zero` is 1 exactly when `acc` is 0x00.
- R12: Opcodes other than 0x00 to 0x03 leave `acc_ovf` unchanged.
- R13: The carry from the low digit into the high digit matches the carry that rippling through the low digit's four bits would give, in both binary directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Execute-phase strobe; the opcode acts on the edge where it is high |
| opcode | input | 8 | Instruction byte to decode |
| reg_data | input | 8 | Contents of the selected register, used by loads |
| acc | output | 8 | Current accumulator value |
| acc_zero | output | 1 | High when the accumulator is zero |
| acc_ovf | output | 1 | Wrap flag from the last count step |

## Verification
The case that is hardest to reach is a digit rollover that also moves the high digit. Examples are 0x39 to 0x40 counting up in decimal, 0x50 to 0x49 counting down, and the full wraps 0x99/0x00. These exercise the decoded low-digit carry and the decimal correction in the same step. The bench reaches each starting value directly by loading it through a 0x6r opcode from `reg_data`, then applies a single step and compares the result. The stability of the wrap flag is checked by setting it with a wrap and then applying clear, load and undefined opcodes before reading it again.

// File: rtl/accum_step_unit.sv
module accum_step_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [7:0] opcode,
  input  logic [7:0] reg_data,
  output logic [7:0] acc,
  output logic       acc_zero,
  output logic       acc_ovf
);

  logic [7:0] acc_q, acc_d;
  logic       ovf_q, ovf_d;

  wire count_dir = opcode[0];
  wire dec_mode  = opcode[1];

  function automatic logic [4:0] digit_step(input logic [3:0] n, input logic cin,
                                            input logic down, input logic dmode);
    logic [4:0] c;
    logic [3:0] r;
    c[0] = cin;
    for (int i = 0; i < 4; i++) begin
      r[i]   = n[i] ^ c[i];
      c[i+1] = down ? (c[i] & ~n[i]) : (c[i] & n[i]);
    end
    if (dmode && cin) begin
      if (!down && n == 4'd9) begin
        r    = 4'd0;
        c[4] = 1'b1;
      end
      if (down && n == 4'd0) r = 4'd9;
    end
    return {c[4], r};
  endfunction

  wire lo_cy = count_dir ? (acc_q[3:0] == 4'd0)
                         : (dec_mode ? (acc_q[3:0] == 4'd9) : (&acc_q[3:0]));

  wire [4:0] lo_step = digit_step(acc_q[3:0], 1'b1, count_dir, dec_mode);
  wire [4:0] hi_step = digit_step(acc_q[7:4], lo_cy, count_dir, dec_mode);

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (exec) begin
      casez (opcode)
        8'b0000_00??: begin
          acc_d = {hi_step[3:0], lo_step[3:0]};
          ovf_d = hi_step[4];
        end
        8'h04:        acc_d = 8'h00;
        8'h05:        acc_d = ~acc_q;
        8'h06:        acc_d = {acc_q[6:0], 1'b0};
        8'h07:        acc_d = {1'b0, acc_q[7:1]};
        8'b1000_0???: acc_d[opcode[2:0]] = 1'b1;
        8'b1000_1???: acc_d[opcode[2:0]] = 1'b0;
        8'b0110_????: acc_d = reg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 8'h00;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc      = acc_q;
  assign acc_ovf  = ovf_q;
  assign acc_zero = (acc_q == 8'h00);

  // R13
  lo_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode[7:1] == 7'b0) |-> (lo_step[4] == lo_cy));

  // R2
  bin_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'h00 && acc == 8'hFF) |=> (acc == 8'h00 && acc_ovf));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'h04) |=> (acc == 8'h00 && acc_zero));

  // R6
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode == 8'h05) |=> (acc == ~$past(acc)));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode[7:4] == 4'b0110) |=> (acc == $past(reg_data)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(acc) && $stable(acc_ovf)));

  // R12
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && opcode[7:2] != 6'b0) |=> $stable(acc_ovf));

endmodule

// File: tb/test_accum_step_unit.sv
module test_accum_step_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] reg_data = 8'h00;
  logic [7:0] acc;
  logic       acc_zero, acc_ovf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  accum_step_unit i_accum_step_unit (
    .clk(clk), .rst_n(rst_n), .exec(exec), .opcode(opcode),
    .reg_data(reg_data), .acc(acc), .acc_zero(acc_zero), .acc_ovf(acc_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {start[25:18], op[17:10], expected[9:2], check_ovf[1], expected_ovf[0]}
  localparam int NV = 19;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h01, 1'b1, 1'b0},  // R2
    {8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},  // R2
    {8'h00, 8'h01, 8'hFF, 1'b1, 1'b1},  // R2
    {8'h10, 8'h01, 8'h0F, 1'b1, 1'b0},  // R2 R13
    {8'h09, 8'h02, 8'h10, 1'b1, 1'b0},  // R3
    {8'h99, 8'h02, 8'h00, 1'b1, 1'b1},  // R3
    {8'h45, 8'h02, 8'h46, 1'b1, 1'b0},  // R3
    {8'h10, 8'h03, 8'h09, 1'b1, 1'b0},  // R4
    {8'h00, 8'h03, 8'h99, 1'b1, 1'b1},  // R4
    {8'h50, 8'h03, 8'h49, 1'b1, 1'b0},  // R4
    {8'h37, 8'h04, 8'h00, 1'b0, 1'b0},  // R5
    {8'h5A, 8'h05, 8'hA5, 1'b0, 1'b0},  // R6
    {8'h81, 8'h06, 8'h02, 1'b0, 1'b0},  // R7
    {8'h81, 8'h07, 8'h40, 1'b0, 1'b0},  // R7
    {8'h00, 8'h87, 8'h80, 1'b0, 1'b0},  // R8
    {8'hFF, 8'h88, 8'hFE, 1'b0, 1'b0},  // R8
    {8'h12, 8'h83, 8'h1A, 1'b0, 1'b0},  // R8
    {8'h0F, 8'h00, 8'h10, 1'b1, 1'b0},  // R13
    {8'h39, 8'h02, 8'h40, 1'b1, 1'b0}   // R3 R13
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] op, input logic [7:0] rd, input logic en);
    @(negedge clk);
    opcode = op; reg_data = rd; exec = en;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", acc, 8'h00);
    check("R1 ovf", acc_ovf, 1'b0);
    check("R1 zero", acc_zero, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 acc after release", acc, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step({4'b0110, i[3:0]}, VEC[i][25:18], 1'b1);
      check("R9 load", acc, VEC[i][25:18]);
      step(VEC[i][17:10], 8'hC3, 1'b1);
      check($sformatf("R2-set op %0h vec %0d acc", VEC[i][17:10], i), acc, VEC[i][9:2]);
      check("R11 zero", acc_zero, VEC[i][9:2] == 8'h00);
      if (VEC[i][1]) check($sformatf("R2 R3 R4 ovf vec %0d", i), acc_ovf, VEC[i][0]);
    end

    step(8'h6A, 8'h7F, 1'b1);
    step(8'h00, 8'h00, 1'b0);
    check("R10 exec low acc", acc, 8'h7F);
    step(8'h20, 8'h00, 1'b1);
    check("R10 undefined op acc", acc, 8'h7F);
    step(8'h00, 8'h00, 1'b1);
    check("R2 7F+1", acc, 8'h80);
    check("R2 ovf clear", acc_ovf, 1'b0);

    step(8'h6B, 8'hFF, 1'b1);
    step(8'h00, 8'h00, 1'b1);
    check("R2 wrap ovf", acc_ovf, 1'b1);
    step(8'h04, 8'h00, 1'b1);
    check("R12 ovf kept by clear", acc_ovf, 1'b1);
    step(8'h65, 8'h55, 1'b1);
    check("R12 ovf kept by load", acc_ovf, 1'b1);
    step(8'h20, 8'h00, 1'b1);
    check("R10 ovf kept by undefined op", acc_ovf, 1'b1);
    check("R10 acc kept by undefined op", acc, 8'h55);
    step(8'h06, 8'h00, 1'b1);
    check("R7 shift left", acc, 8'hAA);
    check("R12 ovf kept by shift", acc_ovf, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule